// File: doc/BRIEF.md
# Three-Slot Instruction Fetch Front End

This block is the front of a simple in-order processor. It holds three instruction slots (fetch, decode and execute), and each slot carries a valid flag, an address and a 32-bit instruction. When a step is requested, the block moves the program counter forward and reads memory at the new address. When the read completes, every slot moves one place toward execute, and the fetched item enters the fetch slot.

An instruction-set select input, `narrow_i`, sets the width of each step. A value of 0 selects 32-bit instructions: the counter moves by 4 and a word is read. A value of 1 selects 16-bit instructions: the counter moves by 2 and a halfword is read. The block samples this input again at every step, so the two widths can be mixed freely.

A branch unit redirects the block through the load port. A load replaces the program counter, cancels any read in progress and empties all slots.

The control state machine has two states:
- `ST_IDLE`: no read is outstanding.
- `ST_WAIT`: a read is presented to memory.

It has four transitions:
- **launch**: `ST_IDLE` to `ST_WAIT`, on a step with no load.
- **commit**: `ST_WAIT` to `ST_IDLE`, when memory is ready and there is no load.
- **abort**: `ST_WAIT` to `ST_IDLE`, on a load.
- **hold**: `ST_WAIT` stays in `ST_WAIT` while memory is not ready. `ST_IDLE` stays in `ST_IDLE` when there is no step, or when a load arrives.

Top module: `insn_fetch_pipe`

## Requirements
- R1: After reset the program counter is 0, all three valid flags are 0 and `mem_req_o` is 0.
- R2: A step with `narrow_i`=0 issues a read with `mem_size_o`=0 (word) at PC+4. On commit the fetch slot holds that address with all 32 data bits, and the PC becomes that address.
- R3: A step with `narrow_i`=1 issues a read with `mem_size_o`=1 (halfword) at PC+2. On commit the fetch slot holds bits [15:0] of the read data with bits [31:16] zero, and the PC becomes that address.
- R4: On each commit, execute takes the previous decode contents, decode takes the previous fetch contents, and fetch takes the new item.
- R5: While a read is outstanding and `mem_ready_i` is 0, `mem_req_o` stays 1. The address, the size, the PC and all slots hold their values.
- R6: A load sets the PC to `pc_load_addr_i` and clears all valid flags. A load takes priority over a step and over a ready read in the same cycle, and that read is discarded.
- R7: After reset or a load, the fetch, decode and execute slots become valid after 1, 2 and 3 commits respectively. A later slot is never valid while an earlier one is not.
- R8: A step that arrives while a read is outstanding is ignored. It produces no extra read and no extra commit.
- R9: The width of a step is taken from `narrow_i` in the cycle the step is accepted. Changing `narrow_i` while the read is outstanding does not alter that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Request to advance by one instruction |
| narrow_i | input | 1 | Instruction-set select: 0 = 32-bit, 1 = 16-bit |
| pc_load_i | input | 1 | Branch redirect strobe |
| pc_load_addr_i | input | 32 | Redirect target |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_size_o | output | 1 | Read size: 0 = word, 1 = halfword |
| mem_rdata_i | input | 32 | Read data; a halfword is taken from bits [15:0] |
| mem_ready_i | input | 1 | Read data valid this cycle; completes the read |
| pc_o | output | 32 | Program counter |
| fetch_valid_o | output | 1 | Fetch slot valid |
| fetch_addr_o | output | 32 | Fetch slot address |
| fetch_instr_o | output | 32 | Fetch slot instruction |
| decode_valid_o | output | 1 | Decode slot valid |
| decode_addr_o | output | 32 | Decode slot address |
| decode_instr_o | output | 32 | Decode slot instruction |
| exec_valid_o | output | 1 | Execute slot valid |
| exec_addr_o | output | 32 | Execute slot address |
| exec_instr_o | output | 32 | Execute slot instruction |

## Verification
The bench steps through all four words, then switches to halfwords, then interleaves the two widths.
- It flips `narrow_i` while a read is outstanding. A design that sampled the width late would present the wrong size, or it would move the counter by the wrong amount.
- It fills memory with distinct bytes in the upper half of each word. A design that failed to zero-extend would show those bytes in a halfword slot.
- It holds the memory back for several cycles. A design that shifted on the request instead of on ready would show slots changing during the stall.
- It sends a redirect in the same cycle as a ready read. It also sends a second step while busy. A design that got the priority wrong would commit a stale item, and one that did not ignore the extra step would commit twice. The scoreboard reports both as unexpected commits.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fetch_state_e;

    localparam logic SIZE_WORD = 1'b0;
    localparam logic SIZE_HALF = 1'b1;

    // Byte distance of one step for the selected instruction width
    function automatic logic [2:0] step_bytes(input logic narrow);
        return narrow ? 3'd2 : 3'd4;
    endfunction

endpackage

// File: rtl/ifp_ctrl.sv
module ifp_ctrl
    import ifp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic load_i,
    input  logic ready_i,
    output logic req_o,
    output logic launch_o,
    output logic commit_o,
    output logic flush_o
);

    fetch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (step_i && !load_i) begin
                    state_d = ST_WAIT;                  // launch
                end
            end
            ST_WAIT: begin
                if (load_i) begin
                    state_d = ST_IDLE;                  // abort
                end else if (ready_i) begin
                    state_d = ST_IDLE;                  // commit
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_o    = 1'b0;
        launch_o = 1'b0;
        commit_o = 1'b0;
        flush_o  = load_i;
        unique case (state_q)
            ST_IDLE: launch_o = step_i && !load_i;
            ST_WAIT: begin
                req_o    = 1'b1;
                commit_o = ready_i && !load_i;
            end
            default: ;
        endcase
    end

    // A commit always returns the machine to idle
    assert_commit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !req_o);

    // A load never leaves a read outstanding
    assert_load_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !req_o);

endmodule

// File: rtl/ifp_pc.sv
module ifp_pc
    import ifp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          commit_i,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          narrow_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] target_o,
    output logic          half_o
);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] tgt_q;
    logic          half_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            tgt_q  <= '0;
            half_q <= SIZE_WORD;
        end else begin
            if (load_i) begin
                pc_q <= load_addr_i;
            end else if (commit_i) begin
                pc_q <= tgt_q;
            end
            if (launch_i) begin
                tgt_q  <= pc_q + AW'(step_bytes(narrow_i));
                half_q <= narrow_i;
            end
        end
    end

    assign pc_o     = pc_q;
    assign target_o = tgt_q;
    assign half_o   = half_q;

endmodule

// File: rtl/ifp_slots.sv
module ifp_slots #(
    parameter int AW    = 32,
    parameter int IW    = 32,
    parameter int DEPTH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_i,
    input  logic                     flush_i,
    input  logic [AW-1:0]            new_addr_i,
    input  logic [IW-1:0]            new_instr_i,
    output logic [DEPTH-1:0]         valid_o,
    output logic [DEPTH-1:0][AW-1:0] addr_o,
    output logic [DEPTH-1:0][IW-1:0] instr_o
);

    logic [DEPTH-1:0]         vld_q;
    logic [DEPTH-1:0][AW-1:0] adr_q;
    logic [DEPTH-1:0][IW-1:0] ins_q;

    // Index 0 is the fetch slot; the highest index is execute
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic          src_v;
        logic [AW-1:0] src_a;
        logic [IW-1:0] src_i;

        if (i == 0) begin : g_head
            assign src_v = 1'b1;
            assign src_a = new_addr_i;
            assign src_i = new_instr_i;
        end else begin : g_tail
            assign src_v = vld_q[i-1];
            assign src_a = adr_q[i-1];
            assign src_i = ins_q[i-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                adr_q[i] <= '0;
                ins_q[i] <= '0;
            end else if (flush_i) begin
                vld_q[i] <= 1'b0;
            end else if (shift_i) begin
                vld_q[i] <= src_v;
                adr_q[i] <= src_a;
                ins_q[i] <= src_i;
            end
        end

        if (i > 0) begin : g_order
            // R7: a slot is never valid ahead of the one before it
            assert_fill_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q[i] |-> vld_q[i-1]);
            // R4: the slot takes its predecessor's contents on a shift
            assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_i && !flush_i) |=> adr_q[i] == $past(adr_q[i-1]));
        end
    end

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> $countones(vld_q) == 0);

    assign valid_o = vld_q;
    assign addr_o  = adr_q;
    assign instr_o = ins_q;

endmodule

// File: rtl/insn_fetch_pipe.sv
module insn_fetch_pipe
    import ifp_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          narrow_i,
    input  logic          pc_load_i,
    input  logic [AW-1:0] pc_load_addr_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_size_o,
    input  logic [IW-1:0] mem_rdata_i,
    input  logic          mem_ready_i,
    output logic [AW-1:0] pc_o,
    output logic          fetch_valid_o,
    output logic [AW-1:0] fetch_addr_o,
    output logic [IW-1:0] fetch_instr_o,
    output logic          decode_valid_o,
    output logic [AW-1:0] decode_addr_o,
    output logic [IW-1:0] decode_instr_o,
    output logic          exec_valid_o,
    output logic [AW-1:0] exec_addr_o,
    output logic [IW-1:0] exec_instr_o
);

    localparam int DEPTH  = 3;
    localparam int HW     = IW / 2;
    localparam int S_FET  = 0;
    localparam int S_DEC  = 1;
    localparam int S_EXE  = DEPTH - 1;

    logic                     launch, commit, flush, req;
    logic [AW-1:0]            target;
    logic                     half;
    logic [IW-1:0]            fill_instr;
    logic [DEPTH-1:0]         s_valid;
    logic [DEPTH-1:0][AW-1:0] s_addr;
    logic [DEPTH-1:0][IW-1:0] s_instr;

    ifp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step_i),
        .load_i   (pc_load_i),
        .ready_i  (mem_ready_i),
        .req_o    (req),
        .launch_o (launch),
        .commit_o (commit),
        .flush_o  (flush)
    );

    ifp_pc #(.AW(AW)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .commit_i    (commit),
        .load_i      (pc_load_i),
        .load_addr_i (pc_load_addr_i),
        .narrow_i    (narrow_i),
        .pc_o        (pc_o),
        .target_o    (target),
        .half_o      (half)
    );

    // Halfword reads use the low half of the data bus, zero-extended
    assign fill_instr = (half == SIZE_HALF) ? {{(IW-HW){1'b0}}, mem_rdata_i[HW-1:0]}
                                            : mem_rdata_i;

    ifp_slots #(.AW(AW), .IW(IW), .DEPTH(DEPTH)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_i     (commit),
        .flush_i     (flush),
        .new_addr_i  (target),
        .new_instr_i (fill_instr),
        .valid_o     (s_valid),
        .addr_o      (s_addr),
        .instr_o     (s_instr)
    );

    assign mem_req_o      = req;
    assign mem_addr_o     = target;
    assign mem_size_o     = half;
    assign fetch_valid_o  = s_valid[S_FET];
    assign fetch_addr_o   = s_addr[S_FET];
    assign fetch_instr_o  = s_instr[S_FET];
    assign decode_valid_o = s_valid[S_DEC];
    assign decode_addr_o  = s_addr[S_DEC];
    assign decode_instr_o = s_instr[S_DEC];
    assign exec_valid_o   = s_valid[S_EXE];
    assign exec_addr_o    = s_addr[S_EXE];
    assign exec_instr_o   = s_instr[S_EXE];

    // R2/R3/R9: a launched read sits at the old PC plus the width sampled at launch
    assert_launch_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> mem_req_o && mem_size_o == $past(narrow_i) &&
                   mem_addr_o == $past(pc_o) + AW'(step_bytes($past(narrow_i))));

    // R5: a stalled read holds its request and leaves PC and slots alone
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i && !pc_load_i) |=>
            mem_req_o && $stable(mem_addr_o) && $stable(mem_size_o) &&
            $stable(pc_o) && $stable(fetch_addr_o) && $stable(fetch_valid_o));

    // R2/R3: a completed read moves the PC onto the read address
    assert_commit_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && !pc_load_i) |=>
            pc_o == $past(mem_addr_o) && fetch_valid_o && fetch_addr_o == $past(mem_addr_o));

    // R6: a load places its target in the PC
    assert_load_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_i |=> pc_o == $past(pc_load_addr_i) && !exec_valid_o);

endmodule

// File: tb/insn_fetch_pipe_tb.sv
module insn_fetch_pipe_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        narrow_i = 1'b0;
    logic        pc_load_i = 1'b0;
    logic [31:0] pc_load_addr_i = '0;
    logic        mem_req_o, mem_size_o, mem_ready_i;
    logic [31:0] mem_addr_o, mem_rdata_i, pc_o;
    logic        fetch_valid_o, decode_valid_o, exec_valid_o;
    logic [31:0] fetch_addr_o, fetch_instr_o, decode_addr_o, decode_instr_o;
    logic [31:0] exec_addr_o, exec_instr_o;

    int n_checks = 0;
    int n_fail   = 0;
    int stall_target = 0;
    int wait_cnt = 0;
    bit force_ready = 1'b0;
    bit chk_pending = 1'b0;
    int cycles = 0;

    logic [63:0] expq[$];
    logic [31:0] exp_pc = '0;
    logic        m_v[3];
    logic [31:0] m_a[3];
    logic [31:0] m_i[3];

    always #10 clk = ~clk;   // 50 MHz

    insn_fetch_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .narrow_i(narrow_i),
        .pc_load_i(pc_load_i), .pc_load_addr_i(pc_load_addr_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o),
        .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i), .pc_o(pc_o),
        .fetch_valid_o(fetch_valid_o), .fetch_addr_o(fetch_addr_o), .fetch_instr_o(fetch_instr_o),
        .decode_valid_o(decode_valid_o), .decode_addr_o(decode_addr_o), .decode_instr_o(decode_instr_o),
        .exec_valid_o(exec_valid_o), .exec_addr_o(exec_addr_o), .exec_instr_o(exec_instr_o)
    );

    function automatic logic [7:0] mb(input logic [31:0] a);
        return 8'((a * 32'd37) ^ (a >> 2) ^ 32'h5A);
    endfunction

    function automatic logic [31:0] mword(input logic [31:0] a);
        return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
    endfunction

    // Memory model: full word on the bus, ready after stall_target waiting cycles
    assign mem_rdata_i = mword(mem_addr_o);
    assign mem_ready_i = mem_req_o && (force_ready || wait_cnt >= stall_target);

    always @(posedge clk) begin
        if (mem_req_o && !mem_ready_i) wait_cnt <= wait_cnt + 1;
        else wait_cnt <= 0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected item after each completed read and compares all slots
    always @(negedge clk) begin
        if (chk_pending) begin
            chk_pending = 1'b0;
            if (expq.size() == 0) begin
                chk(1'b0, "R8", "unexpected commit", {32'h0, fetch_addr_o}, 64'h0);
            end else begin
                logic [63:0] it;
                it = expq.pop_front();
                m_v[2] = m_v[1]; m_a[2] = m_a[1]; m_i[2] = m_i[1];
                m_v[1] = m_v[0]; m_a[1] = m_a[0]; m_i[1] = m_i[0];
                m_v[0] = 1'b1;   m_a[0] = it[63:32]; m_i[0] = it[31:0];
                chk(fetch_valid_o && fetch_addr_o == m_a[0] && fetch_instr_o == m_i[0],
                    "R2/R3", "fetch slot", {fetch_addr_o, fetch_instr_o}, {m_a[0], m_i[0]});
                chk(pc_o == m_a[0], "R2/R3", "pc", {32'h0, pc_o}, {32'h0, m_a[0]});
                chk(decode_valid_o == m_v[1] && (!m_v[1] ||
                    (decode_addr_o == m_a[1] && decode_instr_o == m_i[1])),
                    "R4", "decode slot", {decode_addr_o, decode_instr_o}, {m_a[1], m_i[1]});
                chk(exec_valid_o == m_v[2] && (!m_v[2] ||
                    (exec_addr_o == m_a[2] && exec_instr_o == m_i[2])),
                    "R4", "execute slot", {exec_addr_o, exec_instr_o}, {m_a[2], m_i[2]});
                chk({exec_valid_o, decode_valid_o, fetch_valid_o} == {m_v[2], m_v[1], m_v[0]},
                    "R7", "valid fill", {61'h0, exec_valid_o, decode_valid_o, fetch_valid_o},
                    {61'h0, m_v[2], m_v[1], m_v[0]});
            end
        end
        if (rst_n && mem_req_o && mem_ready_i && !pc_load_i) chk_pending = 1'b1;
    end

    task automatic do_step(input bit nar, input int stalls, input bit dbl);
        logic [31:0] a, d, snap_pc, snap_fa;
        @(negedge clk);
        a = exp_pc + (nar ? 32'd2 : 32'd4);
        d = nar ? {16'h0, mword(a)[15:0]} : mword(a);
        exp_pc = a;
        expq.push_back({a, d});
        narrow_i = nar; stall_target = stalls; step_i = 1'b1;
        @(negedge clk);
        step_i = dbl;
        narrow_i = ~nar;   // R9: must not affect the outstanding read
        chk(mem_req_o && mem_addr_o == a, nar ? "R3" : "R2", "read address",
            {31'h0, mem_req_o, mem_addr_o}, {32'h1, a});
        chk(mem_size_o == nar, "R9", "read size", {63'h0, mem_size_o}, {63'h0, nar});
        snap_pc = pc_o; snap_fa = fetch_addr_o;
        @(negedge clk);
        step_i = 1'b0;
        if (stalls >= 2) begin
            chk(mem_req_o && mem_addr_o == a && pc_o == snap_pc && fetch_addr_o == snap_fa,
                "R5", "stall hold", {pc_o, fetch_addr_o}, {snap_pc, snap_fa});
        end
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
        if (dbl) begin
            repeat (3) @(negedge clk);
            chk(!mem_req_o && pc_o == a, "R8", "busy step ignored",
                {31'h0, mem_req_o, pc_o}, {32'h0, a});
        end
    endtask

    task automatic clear_model(input logic [31:0] tgt);
        exp_pc = tgt;
        for (int k = 0; k < 3; k++) m_v[k] = 1'b0;
    endtask

    task automatic check_flushed(input logic [31:0] tgt, input string what);
        chk(pc_o == tgt, "R6", what, {32'h0, pc_o}, {32'h0, tgt});
        chk(!fetch_valid_o && !decode_valid_o && !exec_valid_o && !mem_req_o, "R6",
            {what, " valids"}, {60'h0, mem_req_o, exec_valid_o, decode_valid_o, fetch_valid_o}, 64'h0);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin m_v[k] = 1'b0; m_a[k] = '0; m_i[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_o == 0 && !fetch_valid_o && !decode_valid_o && !exec_valid_o && !mem_req_o,
            "R1", "reset state", {28'h0, mem_req_o, exec_valid_o, decode_valid_o, fetch_valid_o, pc_o}, 64'h0);

        // 32-bit stream with growing stalls; valids fill one per commit (R7)
        do_step(1'b0, 0, 1'b0);
        do_step(1'b0, 1, 1'b0);
        do_step(1'b0, 2, 1'b0);
        do_step(1'b0, 3, 1'b0);
        // switch to 16-bit stream (R3), zero-extended data
        do_step(1'b1, 2, 1'b0);
        do_step(1'b1, 0, 1'b0);
        do_step(1'b1, 2, 1'b0);
        // interleaved widths (R9)
        do_step(1'b0, 1, 1'b0);
        do_step(1'b1, 2, 1'b0);
        do_step(1'b0, 0, 1'b0);
        // extra step while busy (R8)
        do_step(1'b1, 4, 1'b1);

        // redirect while idle (R6), then refill (R7)
        @(negedge clk);
        pc_load_i = 1'b1; pc_load_addr_i = 32'h40;
        @(negedge clk);
        pc_load_i = 1'b0;
        clear_model(32'h40);
        check_flushed(32'h40, "idle load");
        do_step(1'b1, 1, 1'b0);
        do_step(1'b0, 2, 1'b0);
        do_step(1'b1, 0, 1'b0);

        // redirect in the same cycle as a ready read: read discarded (R6)
        @(negedge clk);
        stall_target = 1000; narrow_i = 1'b0; step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        @(negedge clk);
        pc_load_i = 1'b1; pc_load_addr_i = 32'h80; force_ready = 1'b1;
        @(negedge clk);
        pc_load_i = 1'b0; force_ready = 1'b0;
        clear_model(32'h80);
        check_flushed(32'h80, "abort load");

        // redirect and step together: load wins, no read launched (R6)
        @(negedge clk);
        pc_load_i = 1'b1; pc_load_addr_i = 32'hC2; step_i = 1'b1;
        @(negedge clk);
        pc_load_i = 1'b0; step_i = 1'b0;
        clear_model(32'hC2);
        check_flushed(32'hC2, "load beats step");
        do_step(1'b0, 1, 1'b0);
        do_step(1'b1, 1, 1'b0);
        do_step(1'b1, 0, 1'b0);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule